// File: doc/BRIEF.md
# Two-Bank Vectored Interrupt Controller

This block gathers a set of level-sensitive interrupt lines into a 64-bit pending state. The state is split into two 32-bit banks. Software gates each bank through its own enable and mask words. The block raises one processor request line per bank and presents a vector that gives the lowest-numbered active source. The vector is already scaled to a word offset, so a handler table can be indexed with it directly.

Software reaches the block through a single-cycle register port that decodes a 1 KiB window. Read data is combinational from the addressed word. The window also holds two storage words, a table base and an NMI control word, which have no effect on the interrupt logic. A source bit follows its input line whenever that line changes level. Between changes, software may overwrite the bit, and a write to a pending word stores the complement of the data.

Top module: `vec_intc`

## Requirements
- R1: After reset, every register reads zero and both `irq` and `fiq` are low.
- R2: When source input n changes level, pending bit n%32 of bank n/32 takes the new level on the next clock edge. Bank 0 of the pending state reads at offset 0x10 and bank 1 at offset 0x14.
- R3: A write to offset 0x10 or 0x14 stores the bitwise complement of the write data into that pending bank.
- R4: A source is active when its pending bit is 1, its enable bit is 1 and its mask bit is 0. The enable words sit at 0x20 (bank 0) and 0x24 (bank 1), and the mask words at 0x30 (bank 0) and 0x34 (bank 1).
- R5: Offset 0x00 reads four times the index (bank*32+bit) of the lowest-numbered active source, with bank 0 scanned before bank 1. It reads 0 when no source is active.
- R6: `irq` is high exactly when some bank-0 source is active, and `fiq` is high exactly when some bank-1 source is active. Both update the cycle after the change that causes them.
- R7: A write to offset 0x04 stores the data with bits 1:0 forced to zero. A write to offset 0x0C stores the full word.
- R8: Reads of unmapped offsets return zero, and writes to them change no register. Offset 0x00 is read-only.
- R9: A software-written pending bit keeps its value until its source input next changes level. Pending bits at or above NUM_SRC change only through register writes. A source change takes precedence over a same-cycle write to the same bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src | input | NUM_SRC | Level interrupt source lines |
| bus_valid | input | 1 | Register access strobe for one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address in the window; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed word |
| irq | output | 1 | Request line driven by bank 0 |
| fiq | output | 1 | Request line driven by bank 1 |

## Verification
The bench builds the block with its defaults: NUM_SRC = 41 and ADDR_W = 10. With these values, sources span all of bank 0 and the lower nine bits of bank 1, so vectors for bank-1 sources, such as index 40 at 0xA0, come within reach. The pending bits 41 to 63 have no source, which exercises the write-only part of the pending state. The 10-bit address covers the full window, so the unmapped gaps at 0x08 and above 0x34 can be probed.

// File: rtl/vec_intc.sv
module vec_intc #(
  parameter int NUM_SRC = 41,
  parameter int ADDR_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] src,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              fiq
);
  localparam int WA = ADDR_W - 2;
  localparam logic [WA-1:0] A_VEC  = WA'(8'h00 >> 2);
  localparam logic [WA-1:0] A_BASE = WA'(8'h04 >> 2);
  localparam logic [WA-1:0] A_NMI  = WA'(8'h0C >> 2);
  localparam logic [WA-1:0] A_PND0 = WA'(8'h10 >> 2);
  localparam logic [WA-1:0] A_PND1 = WA'(8'h14 >> 2);
  localparam logic [WA-1:0] A_EN0  = WA'(8'h20 >> 2);
  localparam logic [WA-1:0] A_EN1  = WA'(8'h24 >> 2);
  localparam logic [WA-1:0] A_MSK0 = WA'(8'h30 >> 2);
  localparam logic [WA-1:0] A_MSK1 = WA'(8'h34 >> 2);

  logic [63:0]        pend_q, en_q, msk_q, act;
  logic [31:0]        base_q, nmi_q, vec;
  logic [NUM_SRC-1:0] src_q;
  logic [WA-1:0]      wa;
  logic               we;

  assign wa  = bus_addr[ADDR_W-1:2];
  assign we  = bus_valid & bus_write;
  assign act = pend_q & en_q & ~msk_q;
  assign irq = |act[31:0];
  assign fiq = |act[63:32];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) src_q <= '0;
    else        src_q <= src;

  for (genvar i = 0; i < 64; i++) begin : g_pend
    logic wr_bit;
    assign wr_bit = we && (wa == ((i < 32) ? A_PND0 : A_PND1));
    if (i < NUM_SRC) begin : g_src
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                 pend_q[i] <= 1'b0;
        else if (src[i] != src_q[i]) pend_q[i] <= src[i];
        else if (wr_bit)            pend_q[i] <= ~bus_wdata[i % 32];
    end else begin : g_sw
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)      pend_q[i] <= 1'b0;
        else if (wr_bit) pend_q[i] <= ~bus_wdata[i % 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q   <= '0;
      msk_q  <= '0;
      base_q <= '0;
      nmi_q  <= '0;
    end else if (we) begin
      case (wa)
        A_BASE: base_q        <= {bus_wdata[31:2], 2'b00};
        A_NMI:  nmi_q         <= bus_wdata;
        A_EN0:  en_q[31:0]    <= bus_wdata;
        A_EN1:  en_q[63:32]   <= bus_wdata;
        A_MSK0: msk_q[31:0]   <= bus_wdata;
        A_MSK1: msk_q[63:32]  <= bus_wdata;
        default: ;
      endcase
    end

  always_comb begin
    vec = '0;
    for (int i = 63; i >= 0; i--)
      if (act[i]) vec = 32'(i) << 2;
  end

  always_comb
    case (wa)
      A_VEC:   bus_rdata = vec;
      A_BASE:  bus_rdata = base_q;
      A_NMI:   bus_rdata = nmi_q;
      A_PND0:  bus_rdata = pend_q[31:0];
      A_PND1:  bus_rdata = pend_q[63:32];
      A_EN0:   bus_rdata = en_q[31:0];
      A_EN1:   bus_rdata = en_q[63:32];
      A_MSK0:  bus_rdata = msk_q[31:0];
      A_MSK1:  bus_rdata = msk_q[63:32];
      default: bus_rdata = '0;
    endcase
endmodule

module vec_intc_chk #(
  parameter int NUM_SRC = 41,
  parameter int ADDR_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_SRC-1:0] src,
  input logic [NUM_SRC-1:0] src_q,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [63:0]       pend_q,
  input logic [63:0]       act,
  input logic              irq,
  input logic              fiq
);
  logic rd_vec, rd_map;
  assign rd_vec = bus_addr[ADDR_W-1:2] == '0;
  assign rd_map = bus_addr < ADDR_W'(8'h38) &&
                  bus_addr[ADDR_W-1:2] != ADDR_W'(2) &&
                  bus_addr[ADDR_W-1:2] != ADDR_W'(6) && bus_addr[ADDR_W-1:2] != ADDR_W'(7) &&
                  bus_addr[ADDR_W-1:2] != ADDR_W'(10) && bus_addr[ADDR_W-1:2] != ADDR_W'(11);

  p_src_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src[0] != src_q[0]) |=> (pend_q[0] == $past(src[0])));

  p_pend_inv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr[ADDR_W-1:2] == ADDR_W'(4) && src[31:0] == src_q[31:0])
    |=> (pend_q[31:0] == ~$past(bus_wdata)));

  p_vec_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && act == '0) |-> (bus_rdata == '0));

  p_vec_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && act != '0) |->
      (act[bus_rdata[7:2]] && (act & ((64'd1 << bus_rdata[7:2]) - 64'd1)) == '0
       && bus_rdata[1:0] == 2'b00));

  p_fiq_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && fiq && !irq) |-> (bus_rdata >= 32'd128));

  p_irq_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && irq) |-> (bus_rdata < 32'd128));

  p_base_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[ADDR_W-1:2] == ADDR_W'(1)) |-> (bus_rdata[1:0] == 2'b00));

  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_map |-> (bus_rdata == '0));
endmodule

bind vec_intc vec_intc_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src(src), .src_q(src_q),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend_q(pend_q),
  .act(act), .irq(irq), .fiq(fiq)
);

// File: tb/vec_intc_bench.sv
module vec_intc_bench;
  localparam int NS = 41;
  logic clk = 0, rst_n = 0;
  logic [NS-1:0] src = '0;
  logic bus_valid = 0, bus_write = 0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, fiq;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [63:0] m_pend = '0, m_en = '0, m_msk = '0;
  logic [31:0] m_base = '0, m_nmi = '0;
  logic [NS-1:0] m_src = '0;

  always #2.5 clk = ~clk;

  vec_intc u_vec_intc (.clk(clk), .rst_n(rst_n), .src(src), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .fiq(fiq));

  function automatic logic [63:0] m_act();
    return m_pend & m_en & ~m_msk;
  endfunction

  function automatic logic [31:0] m_vec();
    logic [63:0] a = m_act();
    for (int i = 0; i < 64; i++) if (a[i]) return 32'(i) << 2;
    return 32'd0;
  endfunction

  function automatic logic [31:0] m_read(input logic [9:0] a);
    case (a[9:2])
      8'd0:  return m_vec();
      8'd1:  return m_base;
      8'd3:  return m_nmi;
      8'd4:  return m_pend[31:0];
      8'd5:  return m_pend[63:32];
      8'd8:  return m_en[31:0];
      8'd9:  return m_en[63:32];
      8'd12: return m_msk[31:0];
      8'd13: return m_msk[63:32];
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act_v, exp_v);
    end
  endtask

  task automatic rd(input string req, input logic [9:0] a, input logic [31:0] exp_v);
    bus_addr = a;
    #0.5;
    check(req, bus_rdata, exp_v);
  endtask

  task automatic step(input bit w, input logic [9:0] a, input logic [31:0] d,
                      input logic [NS-1:0] s);
    @(negedge clk);
    src = s; bus_valid = w; bus_write = w; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    if (w) case (a[9:2])
      8'd1:  m_base = {d[31:2], 2'b00};
      8'd3:  m_nmi = d;
      8'd4:  m_pend[31:0] = ~d;
      8'd5:  m_pend[63:32] = ~d;
      8'd8:  m_en[31:0] = d;
      8'd9:  m_en[63:32] = d;
      8'd12: m_msk[31:0] = d;
      8'd13: m_msk[63:32] = d;
      default: ;
    endcase
    for (int n = 0; n < NS; n++) if (s[n] != m_src[n]) m_pend[n] = s[n];
    m_src = s;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic check_all(input string req);
    logic [63:0] a = m_act();
    for (int k = 0; k < 14; k++) rd(req, 10'(k * 4), m_read(10'(k * 4)));
    check(req, {30'd0, irq, fiq}, {30'd0, |a[31:0], |a[63:32]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check_all("R1");
    check("R1", {30'd0, irq, fiq}, 32'd0);

    // R7 storage words
    step(1, 10'h004, 32'hFFFF_FFFF, '0);
    rd("R7", 10'h004, 32'hFFFF_FFFC);
    step(1, 10'h00C, 32'h1234_5677, '0);
    rd("R7", 10'h00C, 32'h1234_5677);

    // R8 vector read-only, unmapped ignored
    step(1, 10'h000, 32'hFFFF_FFFF, '0);
    step(1, 10'h008, 32'hFFFF_FFFF, '0);
    step(1, 10'h3FC, 32'hFFFF_FFFF, '0);
    check_all("R8");
    rd("R8", 10'h008, 32'd0);

    // R2 source 40 sets bank1 bit 8; R4 enable gating; R5 vector 0xA0; R6 fiq
    step(0, '0, '0, NS'(1) << 40);
    rd("R2", 10'h014, 32'h0000_0100);
    check("R6", {31'd0, fiq}, 32'd0);
    step(1, 10'h024, 32'h0000_0100, NS'(1) << 40);
    rd("R5", 10'h000, 32'h0000_00A0);
    check("R6", {30'd0, irq, fiq}, 32'd1);
    // R4 mask blocks
    step(1, 10'h034, 32'h0000_0100, NS'(1) << 40);
    rd("R4", 10'h000, 32'd0);
    check("R4", {31'd0, fiq}, 32'd0);
    step(1, 10'h034, 32'h0, NS'(1) << 40);

    // R5 bank 0 wins over bank 1
    step(1, 10'h020, 32'h8000_0008, (NS'(1) << 40) | NS'(32'h8000_0008));
    rd("R5", 10'h000, 32'h0000_000C);
    check("R6", {30'd0, irq, fiq}, 32'd3);

    // R9 software clear sticks while source held; bits 41+ software only
    step(1, 10'h014, 32'hFFFF_FFFF, (NS'(1) << 40) | NS'(32'h8000_0008));
    rd("R9", 10'h014, 32'd0);
    step(1, 10'h014, 32'h0000_01FF, (NS'(1) << 40) | NS'(32'h8000_0008));
    rd("R3", 10'h014, 32'hFFFF_FE00);
    step(0, '0, '0, (NS'(1) << 40) | NS'(32'h8000_0008));
    rd("R9", 10'h014, 32'hFFFF_FE00);
    // R9 source change beats same-cycle write
    step(1, 10'h010, 32'hFFFF_FFFF, (NS'(1) << 40) | NS'(32'h8000_000C));
    rd("R9", 10'h010, 32'h0000_0004);
    // R2 falling source clears
    step(0, '0, '0, NS'(1) << 40);
    rd("R2", 10'h010, 32'h0000_0000);
    check_all("R9");

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [NS-1:0] s = src;
      logic [9:0] a;
      logic [31:0] d;
      int pick = $urandom % 12;
      if ($urandom % 2) s[$urandom % NS] = ~s[$urandom % NS];
      case (pick)
        0: a = 10'h000; 1: a = 10'h004; 2: a = 10'h00C; 3: a = 10'h010;
        4: a = 10'h014; 5: a = 10'h020; 6: a = 10'h024; 7: a = 10'h030;
        8: a = 10'h034; 9: a = 10'h008;
        default: a = 10'h038 + 10'(($urandom % 242) * 4);
      endcase
      d = (pick == 7 || pick == 8) ? ($urandom & $urandom & $urandom) : $urandom;
      step(($urandom % 3) != 0, a, d, s);
      check_all("R5");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule